// File: doc/BRIEF.md
# Branch, call and stack sequencer

This control block carries out the flow-changing and stack instructions of a small 8-bit processor. It covers jumps, calls, returns, restarts, the jump through HL, loading SP from HL, and push and pop of register pairs. It owns the 16-bit program counter and stack pointer. An upstream fetch stage presents four things:

- the decoded opcode;
- the 16-bit target it has already fetched;
- the address of the next sequential instruction;
- the flag byte, the accumulator and the BC, DE and HL values.

The upstream stage pulses `start`. The sequencer then moves the two bytes of any stack transfer over a byte-wide memory port. It raises `done` for exactly one clock, together with the cycle count of the instruction. A popped pair is returned on `pop_data` and qualified by `pop_load`.

A conditional instruction takes its condition from opcode bits 5:3. It tests one of four flags: sign (bit 7), zero (bit 6), parity (bit 2) and carry (bit 0). The reported cycle count depends on whether the branch is taken.

The controller has six states: `S_IDLE`, `S_WR_HI`, `S_WR_LO`, `S_RD_LO`, `S_RD_HI` and `S_DONE`. Its transitions are as follows:

- From `S_IDLE`, a start moves it to one of three states:
  - `S_WR_HI` for a taken call, a restart or a push;
  - `S_RD_LO` for a taken return or a pop;
  - `S_DONE` for every other opcode.
- `S_WR_HI` always moves to `S_WR_LO`, and `S_WR_LO` always moves to `S_DONE`.
- `S_RD_LO` always moves to `S_RD_HI`, and `S_RD_HI` always moves to `S_DONE`.
- `S_DONE` always returns to `S_IDLE`.

Top module: `branch_stack_seq`

## Requirements
- R1: After reset, pc = 0x0000, sp = 0x0000, done = 0 and mem_we = 0.
- R2: A conditional opcode selects its condition with bits 5:3. The codes 0 to 7 select, in order: Z=0, Z=1, CY=0, CY=1, P=0, P=1, S=0 and S=1. In the flag byte, S is bit 7, Z is bit 6, P is bit 2 and CY is bit 0.
- R3: Jumps are 0xC3 (unconditional) and 11ccc010 (conditional). When taken, pc becomes target and cycles = 10. When not taken, pc becomes next_pc and cycles = 7. A jump makes no memory access.
- R4: Calls are 0xCD (unconditional) and 11ccc100 (conditional). A taken call works as follows:
  - It stores next_pc[15:8] at SP-1 and next_pc[7:0] at SP-2.
  - SP drops by 2.
  - pc becomes target.
  - cycles = 18.

  A call that is not taken writes nothing, sets pc to next_pc and reports cycles = 9.
- R5: Returns are 0xC9 (unconditional, cycles = 10) and 11ccc000 (conditional: cycles = 12 when taken, 6 when not). A taken return reads its low byte at SP and its high byte at SP+1, loads pc with that word and raises SP by 2.
- R6: A restart, 11nnn111, pushes next_pc in the same way as a call, sets pc to nnn*8 (0x00 to 0x38) and reports cycles = 12.
- R7: A push, 11pp0101, stores a pair high byte first at SP-1 and low byte at SP-2. The pair code pp selects 00 = BC, 01 = DE, 10 = HL, or 11 = accumulator (high byte) with flags (low byte). It reports cycles = 12 and sets pc to next_pc.
- R8: A pop, 11pp0001, reads the low byte at SP and the high byte at SP+1, raises SP by 2 and sets pc to next_pc. It presents the word on pop_data with pop_load = 1 in the done cycle and reports cycles = 10. A popped status pair has the accumulator in bits 15:8 and the flags in bits 7:0.
- R9: 0xE9 loads pc from hl and 0xF9 loads sp from hl, sets pc to next_pc. Neither makes a memory access, and both report cycles = 6.
- R10: done is high for exactly one clock. A stack transfer raises done 3 clocks after the start edge; every other opcode raises it 1 clock after. A start asserted while busy is ignored, and pc changes only on the edge that raises done.
- R11: Any other opcode raises done after 1 clock with cycles = 0. It leaves pc and sp unchanged and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `opcode` (sampled in idle only) |
| opcode | input | 8 | Decoded instruction byte |
| target | input | 16 | Branch or call destination already fetched |
| next_pc | input | 16 | Address of the following instruction |
| flags | input | 8 | Flag byte (S=7, Z=6, P=2, CY=0) |
| acc | input | 8 | Accumulator, pushed with the flags |
| bc | input | 16 | BC pair value |
| de | input | 16 | DE pair value |
| hl | input | 16 | HL pair value |
| mem_rdata | input | 8 | Byte read from `mem_addr` (combinational) |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Write strobe |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| done | output | 1 | One-clock completion pulse |
| cycles | output | 5 | Cycle count of the finished instruction |
| pop_data | output | 16 | Word read by a pop |
| pop_load | output | 1 | pop_data valid with done |

## Verification
The bench drives all eight condition codes with flag bytes built in two ways: once over an all-zero background and once over an all-ones background. A design that decoded the wrong bit, or inverted a sense, would then report 7 where 10 is expected, or move pc wrongly. Calls and returns are nested three deep with a restart and pushes of every pair. Each write is compared against the expected address and byte in the cycle it happens, so a byte-order swap or a post-decrement shows up at once. It also exposes a final SP that is off by one. Two further cases target control faults. A start held high across a busy push would, in a design without the busy guard, start a second instruction or corrupt the one in progress. Unsupported opcodes must leave pc and sp alone and report 0 cycles.

// File: rtl/bss_pkg.sv
package bss_pkg;
    parameter int CYC_W = 5;

    typedef enum logic [3:0] {
        K_NONE, K_JMP, K_CALL, K_RET, K_RST, K_PCHL, K_SPHL, K_PUSH, K_POP
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       is_cond;
        logic [2:0] ccc;
        logic [1:0] pair;
    } dec_t;
endpackage

// File: rtl/op_decode.sv
module op_decode
    import bss_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec.kind    = K_NONE;
        dec.is_cond = 1'b0;
        dec.ccc     = opcode[5:3];
        dec.pair    = opcode[5:4];
        unique case (opcode)
            8'hC3: dec.kind = K_JMP;
            8'hCD: dec.kind = K_CALL;
            8'hC9: dec.kind = K_RET;
            8'hE9: dec.kind = K_PCHL;
            8'hF9: dec.kind = K_SPHL;
            default: begin
                if (opcode[7:6] == 2'b11) begin
                    unique case (opcode[2:0])
                        3'b010: begin dec.kind = K_JMP;  dec.is_cond = 1'b1; end
                        3'b100: begin dec.kind = K_CALL; dec.is_cond = 1'b1; end
                        3'b000: begin dec.kind = K_RET;  dec.is_cond = 1'b1; end
                        3'b111: dec.kind = K_RST;
                        3'b101: if (!opcode[3]) dec.kind = K_PUSH;
                        3'b001: if (!opcode[3]) dec.kind = K_POP;
                        default: dec.kind = K_NONE;
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval (
    input  logic [2:0] ccc,
    input  logic       f_s,
    input  logic       f_z,
    input  logic       f_p,
    input  logic       f_cy,
    output logic       cond_true
);
    logic sel_bit;
    always_comb begin
        unique case (ccc[2:1])
            2'd0: sel_bit = f_z;
            2'd1: sel_bit = f_cy;
            2'd2: sel_bit = f_p;
            default: sel_bit = f_s;
        endcase
        // odd codes test the flag set, even codes test it clear
        cond_true = (sel_bit == ccc[0]);
    end
endmodule

// File: rtl/cycle_cost.sv
module cycle_cost
    import bss_pkg::*;
(
    input  kind_e            kind,
    input  logic             is_cond,
    input  logic             taken,
    output logic [CYC_W-1:0] cost
);
    always_comb begin
        unique case (kind)
            K_JMP:   cost = taken ? CYC_W'(10) : CYC_W'(7);
            K_CALL:  cost = taken ? CYC_W'(18) : CYC_W'(9);
            K_RET:   cost = !is_cond ? CYC_W'(10) : (taken ? CYC_W'(12) : CYC_W'(6));
            K_RST:   cost = CYC_W'(12);
            K_PUSH:  cost = CYC_W'(12);
            K_POP:   cost = CYC_W'(10);
            K_PCHL:  cost = CYC_W'(6);
            K_SPHL:  cost = CYC_W'(6);
            default: cost = '0;
        endcase
    end
endmodule

// File: rtl/branch_stack_seq.sv
module branch_stack_seq
    import bss_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [7:0]        flags,
    input  logic [7:0]        acc,
    input  logic [ADDR_W-1:0] bc,
    input  logic [ADDR_W-1:0] de,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W/2-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W/2-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              done,
    output logic [CYC_W-1:0]  cycles,
    output logic [ADDR_W-1:0] pop_data,
    output logic              pop_load
);
    localparam int BYTE_W = ADDR_W / 2;
    localparam int VEC_PAD = ADDR_W - 6;

    typedef enum logic [2:0] {
        S_IDLE, S_WR_HI, S_WR_LO, S_RD_LO, S_RD_HI, S_DONE
    } state_e;

    state_e state, state_n;
    dec_t   dec;
    logic   cond_true, taken;
    logic [CYC_W-1:0]  cost;
    logic [ADDR_W-1:0] word_q, dest_q, push_val;
    logic [CYC_W-1:0]  cyc_q;
    logic              to_pc_q, pop_q;

    op_decode u_dec (.opcode(opcode), .dec(dec));

    cond_eval u_cond (
        .ccc(dec.ccc), .f_s(flags[7]), .f_z(flags[6]), .f_p(flags[2]),
        .f_cy(flags[0]), .cond_true(cond_true)
    );

    assign taken = dec.is_cond ? cond_true : 1'b1;

    cycle_cost u_cost (
        .kind(dec.kind), .is_cond(dec.is_cond), .taken(taken), .cost(cost)
    );

    always_comb begin
        unique case (dec.pair)
            2'd0: push_val = bc;
            2'd1: push_val = de;
            2'd2: push_val = hl;
            default: push_val = {acc, flags};
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (start) begin
                unique case (dec.kind)
                    K_CALL:         state_n = taken ? S_WR_HI : S_DONE;
                    K_RST, K_PUSH:  state_n = S_WR_HI;
                    K_RET:          state_n = taken ? S_RD_LO : S_DONE;
                    K_POP:          state_n = S_RD_LO;
                    default:        state_n = S_DONE;
                endcase
            end
            S_WR_HI: state_n = S_WR_LO;
            S_WR_LO: state_n = S_DONE;
            S_RD_LO: state_n = S_RD_HI;
            S_RD_HI: state_n = S_DONE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            sp      <= '0;
            word_q  <= '0;
            dest_q  <= '0;
            cyc_q   <= '0;
            to_pc_q <= 1'b0;
            pop_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    cyc_q   <= cost;
                    pop_q   <= 1'b0;
                    to_pc_q <= (dec.kind == K_RET);
                    dest_q  <= next_pc;
                    unique case (dec.kind)
                        K_JMP:  pc <= taken ? target : next_pc;
                        K_CALL: if (taken) begin
                                    word_q <= next_pc;
                                    dest_q <= target;
                                    sp     <= sp - ADDR_W'(1);
                                end else pc <= next_pc;
                        K_RST: begin
                            word_q <= next_pc;
                            dest_q <= {{VEC_PAD{1'b0}}, dec.ccc, 3'b000};
                            sp     <= sp - ADDR_W'(1);
                        end
                        K_PUSH: begin
                            word_q <= push_val;
                            sp     <= sp - ADDR_W'(1);
                        end
                        K_RET:  if (!taken) pc <= next_pc;
                        K_POP:  ;
                        K_PCHL: pc <= hl;
                        K_SPHL: begin sp <= hl; pc <= next_pc; end
                        default: ;
                    endcase
                end
                S_WR_HI: sp <= sp - ADDR_W'(1);
                S_WR_LO: pc <= dest_q;
                S_RD_LO: begin
                    word_q[BYTE_W-1:0] <= mem_rdata;
                    sp <= sp + ADDR_W'(1);
                end
                S_RD_HI: begin
                    word_q[ADDR_W-1:BYTE_W] <= mem_rdata;
                    sp <= sp + ADDR_W'(1);
                    if (to_pc_q) pc <= {mem_rdata, word_q[BYTE_W-1:0]};
                    else begin
                        pc    <= dest_q;
                        pop_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we    = (state == S_WR_HI) || (state == S_WR_LO);
        mem_addr  = (state == S_IDLE || state == S_DONE) ? '0 : sp;
        mem_wdata = (state == S_WR_HI) ? word_q[ADDR_W-1:BYTE_W] : word_q[BYTE_W-1:0];
        done      = (state == S_DONE);
        cycles    = cyc_q;
        pop_data  = word_q;
        pop_load  = done && pop_q;
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_pc_moves_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> done);

    p_push_predec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> (sp == $past(sp) - ADDR_W'(1)));

    p_pop_postinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_LO) |=> (sp == $past(sp) + ADDR_W'(1)));

    p_cycle_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles inside {5'd0, 5'd6, 5'd7, 5'd9, 5'd10, 5'd12, 5'd18}));
endmodule

// File: tb/tb_branch_stack_seq.sv
`timescale 1ns/1ps
module tb_branch_stack_seq;
    logic        clk = 0, rst_n = 0, start = 0;
    logic [7:0]  opcode = 0, flags = 0, acc = 0, mem_rdata;
    logic [15:0] target = 0, next_pc = 0, bc = 0, de = 0, hl = 0;
    logic [15:0] mem_addr, pc, sp, pop_data;
    logic [7:0]  mem_wdata;
    logic        mem_we, done, pop_load;
    logic [4:0]  cycles;

    logic [7:0]  mem [0:255];
    logic [23:0] wq [$];
    logic [15:0] m_pc = 0, m_sp = 0;
    int n_chk = 0, n_fail = 0;
    bit prev_done = 0;

    always #5 clk = ~clk;

    branch_stack_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .target(target),
        .next_pc(next_pc), .flags(flags), .acc(acc), .bc(bc), .de(de), .hl(hl),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .pc(pc), .sp(sp), .done(done), .cycles(cycles),
        .pop_data(pop_data), .pop_load(pop_load)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of writes and done width
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) chk(0, "R10", "done wider than one clock", 2, 1);
            prev_done = done;
            if (mem_we) begin
                if (wq.size() == 0) chk(0, "R4", "unexpected write addr", {16'h0, mem_addr}, 0);
                else begin
                    logic [23:0] it;
                    it = wq.pop_front();
                    chk({mem_addr, mem_wdata} == it, "R7", "stack write {addr,data}",
                        {8'h0, mem_addr, mem_wdata}, {8'h0, it});
                end
            end
        end
    end

    function automatic bit cond_ok(input logic [2:0] c, input logic [7:0] f);
        case (c)
            3'd0: return !f[6];
            3'd1: return  f[6];
            3'd2: return !f[0];
            3'd3: return  f[0];
            3'd4: return !f[2];
            3'd5: return  f[2];
            3'd6: return !f[7];
            default: return f[7];
        endcase
    endfunction

    function automatic logic [7:0] mk_flags(input logic [2:0] c, input bit want, input logic [7:0] base);
        logic [7:0] f; int pos;
        f = base;
        case (c[2:1])
            2'd0: pos = 6;
            2'd1: pos = 0;
            2'd2: pos = 2;
            default: pos = 7;
        endcase
        f[pos] = c[0] ? want : !want;
        return f;
    endfunction

    task automatic push_exp(input logic [15:0] v, inout logic [15:0] s);
        wq.push_back({s - 16'd1, v[15:8]});
        wq.push_back({s - 16'd2, v[7:0]});
        s = s - 16'd2;
    endtask

    task automatic exec(input logic [7:0] op, input logic [15:0] tgt, input logic [15:0] npc,
                        input logic [7:0] fl, input bit hold, input string req);
        logic [15:0] e_pc, e_sp, pv, pair;
        int e_cyc, e_lat, lat;
        bit popl;
        logic [2:0] c;
        c = op[5:3]; e_pc = npc; e_sp = m_sp; e_cyc = 0; e_lat = 1; popl = 0;
        pv = {mem[8'(m_sp + 16'd1)], mem[m_sp[7:0]]};
        case (op[5:4])
            2'd0: pair = bc;
            2'd1: pair = de;
            2'd2: pair = hl;
            default: pair = {acc, fl};
        endcase
        casez (op)
            8'hC3: begin e_pc = tgt; e_cyc = 10; end
            8'hCD: begin push_exp(npc, e_sp); e_pc = tgt; e_cyc = 18; e_lat = 3; end
            8'hC9: begin e_pc = pv; e_sp = m_sp + 16'd2; e_cyc = 10; e_lat = 3; end
            8'hE9: begin e_pc = hl; e_cyc = 6; end
            8'hF9: begin e_sp = hl; e_cyc = 6; end
            8'b11???010: begin e_cyc = cond_ok(c, fl) ? 10 : 7; if (cond_ok(c, fl)) e_pc = tgt; end
            8'b11???100: if (cond_ok(c, fl)) begin
                             push_exp(npc, e_sp); e_pc = tgt; e_cyc = 18; e_lat = 3;
                         end else e_cyc = 9;
            8'b11???000: if (cond_ok(c, fl)) begin
                             e_pc = pv; e_sp = m_sp + 16'd2; e_cyc = 12; e_lat = 3;
                         end else e_cyc = 6;
            8'b11???111: begin push_exp(npc, e_sp); e_pc = {10'd0, c, 3'd0}; e_cyc = 12; e_lat = 3; end
            8'b11??0101: begin push_exp(pair, e_sp); e_cyc = 12; e_lat = 3; end
            8'b11??0001: begin e_sp = m_sp + 16'd2; e_cyc = 10; e_lat = 3; popl = 1; end
            default: begin e_pc = m_pc; end
        endcase
        opcode = op; target = tgt; next_pc = npc; flags = fl; start = 1;
        @(negedge clk);
        if (!hold) start = 0; else opcode = 8'hC3;
        lat = 1;
        while (!done && lat < 20) begin @(negedge clk); lat++; end
        start = 0;
        chk(done, req, "done never rose", 0, 1);
        chk(lat == e_lat, "R10", "latency to done", lat, e_lat);
        chk(pc == e_pc, req, "pc", pc, e_pc);
        chk(sp == e_sp, req, "sp", sp, e_sp);
        chk(cycles == 5'(e_cyc), req, "cycles", cycles, e_cyc);
        chk(pop_load == popl, "R8", "pop_load", pop_load, popl);
        if (popl) chk(pop_data == pv, "R8", "pop_data", pop_data, pv);
        chk(wq.size() == 0, req, "missing stack writes", wq.size(), 0);
        wq.delete();
        m_pc = e_pc; m_sp = e_sp;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(pc == 0, "R1", "pc after reset", pc, 0);
        chk(sp == 0, "R1", "sp after reset", sp, 0);
        chk(done == 0 && mem_we == 0, "R1", "done/we after reset", {done, mem_we}, 0);
        rst_n = 1;
        @(negedge clk);

        hl = 16'h0080; exec(8'hF9, 16'h0, 16'h0101, 8'h00, 0, "R9");
        hl = 16'h1234; exec(8'hE9, 16'h0, 16'h0102, 8'h00, 0, "R9");
        exec(8'hC3, 16'h4000, 16'h0103, 8'h00, 0, "R3");

        // every condition, taken and not, on two flag backgrounds
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] ft, ff, base;
                base = b ? 8'hFF : 8'h00;
                ft = mk_flags(3'(c), 1, base);
                ff = mk_flags(3'(c), 0, base);
                exec({2'b11, 3'(c), 3'b010}, 16'h5000 + 16'(c), 16'h0200, ft, 0, "R2,R3");
                exec({2'b11, 3'(c), 3'b010}, 16'h5000 + 16'(c), 16'h0300, ff, 0, "R2,R3");
                exec({2'b11, 3'(c), 3'b100}, 16'h6000, 16'h0403 + 16'(c), ft, 0, "R2,R4");
                exec({2'b11, 3'(c), 3'b000}, 16'h0, 16'h6001, ff, 0, "R2,R5");
                exec({2'b11, 3'(c), 3'b000}, 16'h0, 16'h6002, ft, 0, "R2,R5");
                exec({2'b11, 3'(c), 3'b100}, 16'h6000, 16'h0500, ff, 0, "R2,R4");
            end
        end

        // nested calls, restart, pushes of every pair, returns
        bc = 16'hBEEF; de = 16'hC0DE; hl = 16'hA55A; acc = 8'h5A;
        exec(8'hCD, 16'h2000, 16'h1003, 8'h00, 0, "R4");
        exec(8'hCD, 16'h3000, 16'h2003, 8'h00, 0, "R4");
        exec(8'hEF, 16'h0, 16'h3001, 8'h00, 0, "R6");
        exec(8'hC5, 16'h0, 16'h0029, 8'h00, 0, "R7");
        exec(8'hD5, 16'h0, 16'h002A, 8'h00, 0, "R7");
        exec(8'hE5, 16'h0, 16'h002B, 8'h00, 0, "R7");
        exec(8'hF5, 16'h0, 16'h002C, 8'hD7, 0, "R7");
        exec(8'hC1, 16'h0, 16'h002D, 8'h00, 0, "R8");
        chk(pop_data == {8'h5A, 8'hD7}, "R8", "status pair order", pop_data, {8'h5A, 8'hD7});
        exec(8'hD1, 16'h0, 16'h002E, 8'h00, 0, "R8");
        exec(8'hE1, 16'h0, 16'h002F, 8'h00, 0, "R8");
        exec(8'hF1, 16'h0, 16'h0030, 8'h00, 0, "R8");
        chk(pop_data == 16'hBEEF, "R8", "first pushed pair", pop_data, 16'hBEEF);
        exec(8'hC9, 16'h0, 16'h0031, 8'h00, 0, "R5");
        chk(pc == 16'h3001, "R6", "return from restart", pc, 16'h3001);
        exec(8'hC9, 16'h0, 16'h3002, 8'h00, 0, "R5");
        exec(8'hC9, 16'h0, 16'h2004, 8'h00, 0, "R5");
        chk(pc == 16'h1003 && sp == 16'h0080, "R5", "unwound pc/sp", {pc, sp}, {16'h1003, 16'h0080});

        // all restart vectors
        for (int c = 0; c < 8; c++) begin
            exec({2'b11, 3'(c), 3'b111}, 16'h0, 16'h7100 + 16'(c), 8'h00, 0, "R6");
            exec(8'hC9, 16'h0, 16'h0001, 8'h00, 0, "R5");
        end

        // start held high while busy
        bc = 16'h1357;
        exec(8'hC5, 16'h0, 16'h0800, 8'h00, 1, "R10");
        exec(8'hD1, 16'h0, 16'h0801, 8'h00, 0, "R10");
        chk(pop_data == 16'h1357 && sp == 16'h0080, "R10", "busy start ignored", {pop_data, sp}, {16'h1357, 16'h0080});

        // unsupported opcodes
        exec(8'h00, 16'h9999, 16'h0900, 8'hFF, 0, "R11");
        exec(8'h76, 16'h9999, 16'h0901, 8'hFF, 0, "R11");
        exec(8'hDD, 16'h9999, 16'h0902, 8'hFF, 0, "R11");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule